// File: doc/BRIEF.md
# Timepulse Generator with Edge Snapping

The block produces a periodic output pulse from a single fixed reference clock of nominally 48 MHz. An internal ideal time base advances by one reference cycle per clock, plus an optional signed drift term. The block places every output transition on the reference edge nearest to its ideal instant. The rate can be anything from 1 Hz up to well above 10 MHz. Because of that placement, the output carries two kinds of jitter. Divider jitter appears when the period is not a whole number of reference cycles. A slow sawtooth slip of one cycle appears when the reference drifts.

The period is programmed as an unsigned fixed-point number of reference cycles with 32 fractional bits. The high time is set as a fraction of the period in 1/256 steps, and 128 gives a square wave. For each transition the block reports the signed fractional distance between the ideal instant and the clock edge actually used. A downstream unit can use that value to undo the quantisation.

Top module: `tpg_top`

## Requirements
- R1: While reset is asserted, and in the first clock after release (the arming cycle, counted as cycle 0), pulse_o and edge_o are 0 and resid_o is 0. The first transition is a rising one, aimed at one full period after the arming cycle.
- R2: Ideal time at cycle c is c*step, with step = 2^32 + drift_i in units of 2^-32 cycle. A transition with target T is issued in the first cycle c where T - c*step < 2^31, so an exact half-cycle tie goes to the later edge. Each target is the previous target plus the interval, so rounding never accumulates.
- R3: On a transition cycle, resid_o equals T - c*step as a 34-bit two's complement value in units of 2^-32 cycle. Between transitions resid_o holds its last value.
- R4: Every reported residual lies in [-2^31 - |drift_i|, 2^31).
- R5: An integer period with zero drift gives a constant rising-to-rising spacing. A non-integer period gives spacings that take only the two neighbouring integer values, and both of them occur.
- R6: The high time target is floor(period_i * duty_i / 256) and the low time is the rest of the period. A duty_i of 0 is treated as 1.
- R7: A positive drift_i makes occasional rising-to-rising spacings one cycle shorter than the integer period. A negative drift_i makes them one cycle longer.
- R8: edge_o is 1 for exactly the clock cycles in which pulse_o changes, and pulse_o is stable in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| period_i | input | 59 | Period in reference cycles, 27 integer and 32 fractional bits |
| duty_i | input | 8 | High time as a fraction of the period in 1/256 steps |
| drift_i | input | 28 | Signed per-cycle offset to the time base step, in units of 2^-32 cycle |
| pulse_o | output | 1 | Snapped output pulse |
| edge_o | output | 1 | One-cycle strobe in each cycle where pulse_o changes |
| resid_o | output | 34 | Signed residual of the latest transition, in units of 2^-32 cycle |

## Verification
A corrupted remaining-time register shows at the ports within one period. The next transition lands in the wrong cycle, and its residual departs from the value predicted from the chained targets. A wrong step or interval value is harder to see in a single edge, because rounding can hide it. It does show after a few periods as a wrong spacing pattern: a missing or extra long gap for fractional periods, or a slip in the wrong direction under drift. Level or strobe faults show in the very cycle they occur, as pulse_o changing without edge_o or the reverse.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } level_e;
endpackage

// File: rtl/tpg_step.sv
// Per-cycle advance of the ideal time base: one cycle plus signed drift.
module tpg_step #(
    parameter int FRAC_W  = 32,
    parameter int DRIFT_W = 28
) (
    input  logic signed [DRIFT_W-1:0] drift_i,
    output logic        [FRAC_W+1:0]  step_o
);
    localparam int STEP_W = FRAC_W + 2;
    localparam logic [STEP_W-1:0] ONE_CYCLE = {2'b01, {FRAC_W{1'b0}}};

    logic [STEP_W-1:0] drift_ext;

    always_comb begin
        drift_ext = {{(STEP_W-DRIFT_W){drift_i[DRIFT_W-1]}}, drift_i};
        step_o    = ONE_CYCLE + drift_ext;
    end
endmodule

// File: rtl/tpg_span.sv
// Splits the period into high and low intervals from the duty setting.
module tpg_span #(
    parameter int FRAC_W = 32,
    parameter int INT_W  = 27,
    parameter int DUTY_W = 8
) (
    input  logic [INT_W+FRAC_W-1:0] period_i,
    input  logic [DUTY_W-1:0]       duty_i,
    output logic [INT_W+FRAC_W-1:0] high_o,
    output logic [INT_W+FRAC_W-1:0] low_o
);
    localparam int PER_W  = INT_W + FRAC_W;
    localparam int PROD_W = PER_W + DUTY_W;

    logic [DUTY_W-1:0] duty_c;
    logic [PROD_W-1:0] prod;

    always_comb begin
        // R6: a zero duty would give a zero-length high time; force one step
        duty_c = (duty_i == '0) ? DUTY_W'(1) : duty_i;
        prod   = {{DUTY_W{1'b0}}, period_i} * {{PER_W{1'b0}}, duty_c};
        high_o = prod[PROD_W-1:DUTY_W];
        low_o  = period_i - high_o;
    end
endmodule

// File: rtl/tpg_phase.sv
// Remaining-time register: counts down toward the next target and snaps
// the transition to the nearest reference edge.
module tpg_phase
    import tpg_pkg::*;
#(
    parameter int FRAC_W  = 32,
    parameter int INT_W   = 27,
    parameter int DRIFT_W = 28
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [INT_W+FRAC_W-1:0]  period_i,
    input  logic [FRAC_W+1:0]        step_i,
    input  logic [INT_W+FRAC_W-1:0]  high_i,
    input  logic [INT_W+FRAC_W-1:0]  low_i,
    output logic                     pulse_o,
    output logic                     edge_o,
    output logic signed [FRAC_W+1:0] resid_o
);
    localparam int PER_W = INT_W + FRAC_W;
    localparam int REM_W = PER_W + 2;
    localparam int RES_W = FRAC_W + 2;
    localparam logic signed [REM_W-1:0] REM_HALF = REM_W'(1) << (FRAC_W-1);
    localparam logic signed [RES_W-1:0] RES_HI   = RES_W'(1) << (FRAC_W-1);
    localparam logic signed [RES_W-1:0] RES_DM   = RES_W'(1) << (DRIFT_W-1);
    localparam logic signed [RES_W-1:0] RES_LO   = -RES_HI - RES_DM;

    typedef struct packed {
        logic             armed;
        level_e           level;
        logic             fire;
        logic [REM_W-1:0] rem;
        logic [RES_W-1:0] resid;
    } state_t;

    state_t s_d, s_q;
    logic signed [REM_W-1:0] rem_nx;
    logic        [PER_W-1:0] span_nx;

    always_comb begin
        s_d      = s_q;
        s_d.fire = 1'b0;
        rem_nx   = $signed(s_q.rem) - $signed({{(REM_W-FRAC_W-2){1'b0}}, step_i});
        span_nx  = (s_q.level == LVL_LOW) ? high_i : low_i;
        if (!s_q.armed) begin
            s_d.armed = 1'b1;
            s_d.rem   = {2'b00, period_i};
        end else if (rem_nx < REM_HALF) begin
            s_d.fire  = 1'b1;
            s_d.level = (s_q.level == LVL_LOW) ? LVL_HIGH : LVL_LOW;
            s_d.resid = rem_nx[RES_W-1:0];
            s_d.rem   = rem_nx + $signed({2'b00, span_nx});
        end else begin
            s_d.rem   = rem_nx;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign pulse_o = (s_q.level == LVL_HIGH);
    assign edge_o  = s_q.fire;
    assign resid_o = $signed(s_q.resid);

    assert_unarmed_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !s_q.armed |-> (!pulse_o && !edge_o && resid_o == '0));

    assert_resid_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        edge_o |-> (resid_o < RES_HI && resid_o >= RES_LO));

    assert_resid_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !edge_o |-> $stable(resid_o));

    assert_edge_toggles_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        edge_o |-> (pulse_o != $past(pulse_o)));

    assert_level_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !edge_o |-> (pulse_o == $past(pulse_o)));
endmodule

// File: rtl/tpg_top.sv
module tpg_top #(
    parameter int FRAC_W  = 32,
    parameter int INT_W   = 27,
    parameter int DUTY_W  = 8,
    parameter int DRIFT_W = 28
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [INT_W+FRAC_W-1:0]    period_i,
    input  logic [DUTY_W-1:0]          duty_i,
    input  logic signed [DRIFT_W-1:0]  drift_i,
    output logic                       pulse_o,
    output logic                       edge_o,
    output logic signed [FRAC_W+1:0]   resid_o
);
    localparam int PER_W = INT_W + FRAC_W;

    logic [FRAC_W+1:0] step;
    logic [PER_W-1:0]  high_len;
    logic [PER_W-1:0]  low_len;

    tpg_step #(.FRAC_W(FRAC_W), .DRIFT_W(DRIFT_W)) step_i (
        .drift_i (drift_i),
        .step_o  (step)
    );

    tpg_span #(.FRAC_W(FRAC_W), .INT_W(INT_W), .DUTY_W(DUTY_W)) span_i (
        .period_i (period_i),
        .duty_i   (duty_i),
        .high_o   (high_len),
        .low_o    (low_len)
    );

    tpg_phase #(.FRAC_W(FRAC_W), .INT_W(INT_W), .DRIFT_W(DRIFT_W)) phase_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .period_i (period_i),
        .step_i   (step),
        .high_i   (high_len),
        .low_i    (low_len),
        .pulse_o  (pulse_o),
        .edge_o   (edge_o),
        .resid_o  (resid_o)
    );
endmodule

// File: tb/tpg_top_tb_top.sv
module tpg_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam longint ONE  = 64'sd4294967296;
    localparam longint HALF = 64'sd2147483648;

    typedef struct packed {
        longint per;
        int     duty;
        int     drift;
        int     nedge;
        int     gmin;
        int     gmax;
    } vec_t;

    // period, duty, drift, transitions, expected min/max rising spacing
    localparam vec_t VECS [0:7] = '{
        '{64'sd206158430208,  128, 0,         8,  48,  48},  // 48.0 cycles
        '{64'sd20615843021,   128, 0,         20, 4,   5},   // 4.8 cycles
        '{64'sd17179869184,   128, 0,         12, 4,   4},   // 4.0 cycles
        '{64'sd34359738368,   64,  0,         10, 8,   8},   // 8.0 cycles, 25 %
        '{64'sd25769803776,   128, 85899346,  40, 5,   6},   // fast reference
        '{64'sd25769803776,   128, -85899346, 40, 6,   7},   // slow reference
        '{64'sd2199023255552, 0,   0,         4,  512, 512}, // duty 0 clamp
        '{64'sd2199023255552, 255, 0,         4,  512, 512}  // near-full duty
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [58:0]        period = '0;
    logic [7:0]         duty = '0;
    logic signed [27:0] drift = '0;
    logic               pulse;
    logic               edge_s;
    logic signed [33:0] resid;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tpg_top dut_i (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .period_i (period),
        .duty_i   (duty),
        .drift_i  (drift),
        .pulse_o  (pulse),
        .edge_o   (edge_s),
        .resid_o  (resid)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(!pulse && !edge_s && resid == 0, "R1 reset state", longint'({pulse, edge_s}) + longint'(resid), 0);
        rst_n = 1'b1;
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        longint inc, tgt, hi, lo, expc, cyc, last_res, rise_prev, expr, dmag;
        int  dutyc, gmin, gmax;
        bit  lvl, bad;
        period = v.per[58:0];
        duty   = v.duty[7:0];
        drift  = v.drift[27:0];
        do_reset();
        inc      = ONE + longint'(v.drift);
        dmag     = (v.drift < 0) ? -longint'(v.drift) : longint'(v.drift);
        dutyc    = (v.duty == 0) ? 1 : v.duty;
        hi       = (v.per * dutyc) >>> 8;
        lo       = v.per - hi;
        tgt      = v.per;
        lvl      = 1'b0;
        last_res = 0;
        rise_prev = -1;
        gmin     = 32'h7fffffff;
        gmax     = 0;
        cyc      = -1;
        for (int e = 0; e < v.nedge; e++) begin
            expc = (tgt - HALF) / inc + 1;
            bad  = 1'b0;
            while (cyc < expc) begin
                @(posedge clk);
                cyc++;
                @(negedge clk);
                if (cyc < expc && (edge_s || pulse != lvl || resid != last_res)) bad = 1'b1;
            end
            check(!bad, $sformatf("R8/R3 quiet before transition %0d of vector %0d", e, idx), longint'(bad), 0);
            check(edge_s, $sformatf("R2 strobe at cycle %0d (vector %0d)%s", expc, idx,
                  (e == 0) ? " R1 first" : ""), longint'(edge_s), 1);
            lvl = ~lvl;
            check(pulse == lvl, $sformatf("R8 level after transition %0d of vector %0d", e, idx),
                  longint'(pulse), longint'(lvl));
            expr = tgt - expc * inc;
            check(longint'(resid) == expr, $sformatf("R3 residual vector %0d transition %0d", idx, e),
                  longint'(resid), expr);
            check(longint'(resid) < HALF && longint'(resid) >= -HALF - dmag,
                  $sformatf("R4 residual bound vector %0d", idx), longint'(resid), expr);
            last_res = expr;
            if (lvl) begin
                if (rise_prev >= 0) begin
                    if (int'(expc - rise_prev) < gmin) gmin = int'(expc - rise_prev);
                    if (int'(expc - rise_prev) > gmax) gmax = int'(expc - rise_prev);
                end
                rise_prev = expc;
                tgt += hi;
            end else begin
                tgt += lo;
            end
        end
        check(gmin == v.gmin, $sformatf("R5/R6/R7 shortest spacing vector %0d", idx), gmin, v.gmin);
        check(gmax == v.gmax, $sformatf("R5/R6/R7 longest spacing vector %0d", idx), gmax, v.gmax);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) run_vec(VECS[i], i);

        // R1: reset in the middle of a high phase clears everything
        period = 59'(VECS[1].per);
        duty   = 8'd128;
        drift  = '0;
        do_reset();
        repeat (6) @(negedge clk);
        check(pulse && resid != 0, "R1 running before reset", longint'(pulse), 1);
        rst_n = 1'b0;
        #1;
        check(!pulse && !edge_s && resid == 0, "R1 asynchronous clear",
              longint'(pulse) + longint'(resid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!pulse && !edge_s && resid == 0, "R1 arming cycle quiet",
              longint'(pulse) + longint'(resid), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule